// File: doc/BRIEF.md
# Vectored Interrupt Controller

The controller gathers a wide set of interrupt request lines, spread over 32-bit banks, and presents one interrupt line to a processor. Software reaches it through a simple 32-bit register port. Through that port it can read which sources are pending, choose which sources are enabled and which are masked, and read a vector word. The vector word names the lowest-numbered source that is currently qualified. A source is qualified when it is pending, enabled and not masked.

Source 0 is the external line and behaves differently from the others. It latches, and it stays pending until software clears it by writing a one. All other sources are level-followers and need no acknowledge. Source 0 also produces the same vector word as "nothing pending". For that reason, software reads the pending bit of source 0 to tell the two cases apart.

A build parameter chooses where the enable and mask banks sit in the register map. Sources map to banks in a fixed way: source n lives in bank n/32 at bit n%32.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source n appears in bank n/32 at bit n%32. This holds for the pending banks (0x10 + 4*bank), the enable banks and the mask banks.
- R2: Offset 0x00 is the vector word. It reads the winning source number in bits [8:2], and every other bit reads zero. It reads all zeros when no source is qualified, and also when source 0 wins.
- R3: When several sources are qualified in the same cycle, the lowest-numbered one is reported.
- R4: A source is qualified only when its pending bit is 1, its enable bit is 1 and its mask bit is 0. An unqualified source never reaches the vector word or the interrupt output.
- R5: The interrupt output `cpu_irq` is the OR of all qualified sources. It is registered, so it changes one clock after the pending, enable or mask state that causes it.
- R6: For sources 1 and above, the pending bit equals the request level sampled at the previous clock edge. Writing ones to their pending bits leaves them unchanged.
- R7: When bit 0 of the external-line control register (offset 0x0c) is 0, source 0 is edge-latched. It becomes pending on a rising edge of its line and stays pending until bit 0 of pending bank 0 is written with 1. A line that is still held high after that clear does not set it again.
- R8: When bit 0 of the external-line control register is 1, source 0 is level-latched. It is set in every cycle in which its line is high, so a clear takes hold only once the line is low.
- R9: In a write to pending bank 0, a 0 in bit 0 leaves the pending bit of source 0 unchanged, and a 1 clears it. An all-ones word clears it too.
- R10: The protection register (offset 0x08) and the external-line control register (offset 0x0c) each store bit 0 only. Their other bits read zero.
- R11: With `ALT_LAYOUT`=0 the enable banks are at 0x40 + 4*bank and the mask banks at 0x50 + 4*bank. With `ALT_LAYOUT`=1 they are at 0x20 + 4*bank and 0x30 + 4*bank.
- R12: Every register resets to zero. Reads of unmapped offsets return zero, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NBANK*32 | Interrupt request lines, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cpu_irq | output | 1 | Registered interrupt output to the processor |

## Verification
The clear of source 0 by software can land in the same cycle as the latching of source 0 by its line. The bench provokes this by writing the clear while the line is held high, once in each trigger mode. In edge mode it expects the clear to win and the bit to stay low. In level mode it expects the line to win and the bit to read back set. A second coincidence also needs attention: a write that clears the pending bits of level-following sources whose lines are still asserted. The bench judges this by reading the pending bank back, both before and after the line drops.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_VEC,
    RK_PROT,
    RK_EXT,
    RK_PEND,
    RK_EN,
    RK_MSK
  } reg_kind_e;

  // Vector word: source number placed at bit 2, zero when nothing wins.
  function automatic logic [WORD_W-1:0] vec_word(input int unsigned idx, input logic valid);
    logic [WORD_W-1:0] w;
    w = WORD_W'(idx) << 2;
    return valid ? w : '0;
  endfunction

  // Byte offset of bank b in a bank group starting at base.
  function automatic int unsigned bank_offset(input int unsigned base, input int unsigned b);
    return base + 4 * b;
  endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NBANK      = 3,
  parameter bit ALT_LAYOUT = 1'b0,
  localparam int BIDX_W    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [BIDX_W-1:0] bank
);

  localparam int VEC_OFF   = 'h00;
  localparam int PROT_OFF  = 'h08;
  localparam int EXT_OFF   = 'h0c;
  localparam int PEND_BASE = 'h10;
  localparam int EN_BASE   = ALT_LAYOUT ? 'h20 : 'h40;
  localparam int MSK_BASE  = ALT_LAYOUT ? 'h30 : 'h50;

  always_comb begin
    kind = RK_NONE;
    bank = '0;
    if (addr == ADDR_W'(VEC_OFF))  kind = RK_VEC;
    if (addr == ADDR_W'(PROT_OFF)) kind = RK_PROT;
    if (addr == ADDR_W'(EXT_OFF))  kind = RK_EXT;
    for (int b = 0; b < NBANK; b++) begin
      if (addr == ADDR_W'(bank_offset(PEND_BASE, b))) begin
        kind = RK_PEND;
        bank = BIDX_W'(b);
      end
      if (addr == ADDR_W'(bank_offset(EN_BASE, b))) begin
        kind = RK_EN;
        bank = BIDX_W'(b);
      end
      if (addr == ADDR_W'(bank_offset(MSK_BASE, b))) begin
        kind = RK_MSK;
        bank = BIDX_W'(b);
      end
    end
  end

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int NSRC = 96
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            ext_level,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);

  logic req0_q;
  logic live_q;
  logic src0_edge;
  logic src0_set;
  logic src0_clr;

  assign src0_edge = req[0] & ~req0_q;
  assign src0_set  = ext_level ? req[0] : src0_edge;
  assign src0_clr  = clr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      req0_q <= 1'b0;
      live_q <= 1'b0;
    end else begin
      pend[0]        <= src0_set | (pend[0] & ~src0_clr);
      pend[NSRC-1:1] <= req[NSRC-1:1];
      req0_q         <= req[0];
      live_q         <= 1'b1;
    end
  end

  // R7
  src0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] && !src0_clr |=> pend[0]);

  // R7
  src0_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_level && !pend[0] && req0_q |=> !pend[0]);

  // R8
  src0_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_level && req[0] |=> pend[0]);

  // R6
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> pend[NSRC-1:1] == $past(req[NSRC-1:1]));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NSRC  = 96,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  qual,
  output logic [IDX_W-1:0] win_idx,
  output logic             win_valid,
  output logic             irq_q
);

  localparam logic [NSRC-1:0] ONE = NSRC'(1);

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (qual[i]) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= win_valid;
  end

  // R3
  winner_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> qual[win_idx]);

  // R3
  winner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (qual & ((ONE << win_idx) - ONE)) == '0);

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(qual != '0));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NBANK      = 3,
  parameter bit ALT_LAYOUT = 1'b0,
  localparam int NSRC      = NBANK * WORD_W,
  localparam int IDX_W     = $clog2(NSRC),
  localparam int BIDX_W    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              cpu_irq
);

  reg_kind_e         rk;
  logic [BIDX_W-1:0] rbank;

  logic [WORD_W-1:0] en_q  [NBANK];
  logic [WORD_W-1:0] msk_q [NBANK];
  logic              prot_q;
  logic              ext_q;

  logic [NSRC-1:0]   en_flat;
  logic [NSRC-1:0]   msk_flat;
  logic [NSRC-1:0]   pend_flat;
  logic [NSRC-1:0]   pend_clr;
  logic [NSRC-1:0]   qual;
  logic [WORD_W-1:0] pend_bank [NBANK];

  logic [IDX_W-1:0]  win_idx;
  logic              win_valid;

  irqc_decode #(
    .ADDR_W    (ADDR_W),
    .NBANK     (NBANK),
    .ALT_LAYOUT(ALT_LAYOUT)
  ) u_dec (
    .addr(reg_addr),
    .kind(rk),
    .bank(rbank)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign en_flat [b*WORD_W +: WORD_W] = en_q[b];
      assign msk_flat[b*WORD_W +: WORD_W] = msk_q[b];
      assign pend_bank[b]                 = pend_flat[b*WORD_W +: WORD_W];
      assign pend_clr[b*WORD_W +: WORD_W] =
        (reg_wr && rk == RK_PEND && rbank == BIDX_W'(b)) ? reg_wdata : '0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q[b]  <= '0;
          msk_q[b] <= '0;
        end else if (reg_wr && rbank == BIDX_W'(b)) begin
          if (rk == RK_EN)  en_q[b]  <= reg_wdata;
          if (rk == RK_MSK) msk_q[b] <= reg_wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      ext_q  <= 1'b0;
    end else if (reg_wr) begin
      if (rk == RK_PROT) prot_q <= reg_wdata[0];
      if (rk == RK_EXT)  ext_q  <= reg_wdata[0];
    end
  end

  irqc_pending #(.NSRC(NSRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (irq_req),
    .ext_level(ext_q),
    .clr      (pend_clr),
    .pend     (pend_flat)
  );

  assign qual = pend_flat & en_flat & ~msk_flat;

  irqc_arbiter #(.NSRC(NSRC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .qual     (qual),
    .win_idx  (win_idx),
    .win_valid(win_valid),
    .irq_q    (cpu_irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (rk)
      RK_VEC:  reg_rdata = vec_word(32'(win_idx), win_valid);
      RK_PROT: reg_rdata = {{(WORD_W-1){1'b0}}, prot_q};
      RK_EXT:  reg_rdata = {{(WORD_W-1){1'b0}}, ext_q};
      RK_PEND: reg_rdata = pend_bank[rbank];
      RK_EN:   reg_rdata = en_q[rbank];
      RK_MSK:  reg_rdata = msk_q[rbank];
      default: reg_rdata = '0;
    endcase
  end

  // R2
  vec_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rk == RK_VEC |-> reg_rdata[1:0] == 2'b00 && (reg_rdata >> (IDX_W + 2)) == '0);

  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rk == RK_NONE |-> reg_rdata == '0);

  // R10
  ctl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rk == RK_PROT || rk == RK_EXT) |-> reg_rdata[WORD_W-1:1] == '0);

  // R4
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_flat & en_flat) == '0 |=> !cpu_irq);

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

  localparam int NS = 96;

  typedef struct packed {
    logic [NS-1:0] req;
    logic [NS-1:0] en;
    logic [NS-1:0] msk;
    logic [31:0]   vec;
    logic          irq;
  } vec_t;

  localparam logic [NS-1:0] ALL = {NS{1'b1}};
  localparam logic [NS-1:0] B1  = NS'(1);

  // Sources 1..95 only; expected vector = winner << 2 (R2, R3, R4).
  localparam vec_t TBL [10] = '{
    '{B1 << 5,               ALL, '0,       32'h014, 1'b1},
    '{(B1 << 40) | (B1 << 7), ALL, '0,       32'h01c, 1'b1},
    '{(B1 << 40) | (B1 << 7), ALL, B1 << 7,  32'h0a0, 1'b1},
    '{(B1 << 40) | (B1 << 7), 96'h0000_0000_ffff_ffff_0000_0000, '0, 32'h0a0, 1'b1},
    '{B1 << 95,              ALL, '0,       32'h17c, 1'b1},
    '{B1 << 95,              ALL, B1 << 95, 32'h000, 1'b0},
    '{(B1 << 64) | (B1 << 95), B1 << 95, '0, 32'h17c, 1'b1},
    '{'0,                    ALL, '0,       32'h000, 1'b0},
    '{(B1 << 33) | (B1 << 34), ALL, '0,     32'h084, 1'b1},
    '{(B1 << 63) | (B1 << 64), ALL, '0,     32'h0fc, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_req = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   rdata, rdata_alt;
  logic          irq, irq_alt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.ALT_LAYOUT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata), .cpu_irq(irq)
  );

  irq_vector_ctrl #(.ALT_LAYOUT(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_alt), .cpu_irq(irq_alt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] da);
    reg_addr = a;
    #1;
    d  = rdata;
    da = rdata_alt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, va;
    step();
    step();
    // R12: reset state
    rd(8'h00, v, va); check("R12 vector after reset", v, 0);
    rd(8'h08, v, va); check("R12 prot after reset", v, 0);
    rd(8'h0c, v, va); check("R12 extctl after reset", v, 0);
    rd(8'h10, v, va); check("R12 pending after reset", v, 0);
    rd(8'h40, v, va); check("R12 enable after reset", v, 0);
    rd(8'h50, v, va); check("R12 mask after reset", v, 0);
    check("R12 irq after reset", 32'(irq), 0);
    rst_n = 1'b1;
    step();

    // Table walk: R2 R3 R4 R5
    for (int e = 0; e < 10; e++) begin
      for (int b = 0; b < 3; b++) begin
        wr(8'(8'h40 + 4 * b), TBL[e].en[b*32 +: 32]);
        wr(8'(8'h50 + 4 * b), TBL[e].msk[b*32 +: 32]);
      end
      irq_req = TBL[e].req;
      step();
      rd(8'h00, v, va);
      check($sformatf("R3 R4 vector entry %0d", e), v, TBL[e].vec);
      step();
      check($sformatf("R5 irq entry %0d", e), 32'(irq), 32'(TBL[e].irq));
    end
    irq_req = '0;
    for (int b = 0; b < 3; b++) begin
      wr(8'(8'h40 + 4 * b), 32'h0);
      wr(8'(8'h50 + 4 * b), 32'h0);
    end

    // R1: source 37 -> bank 1 bit 5
    irq_req[37] = 1'b1;
    step();
    rd(8'h14, v, va); check("R1 pending bank1 bit5", v, 32'h20);
    rd(8'h10, v, va); check("R1 pending bank0 empty", v, 0);
    rd(8'h18, v, va); check("R1 pending bank2 empty", v, 0);
    // R6: write-ones while line high has no effect
    wr(8'h14, 32'hffff_ffff);
    rd(8'h14, v, va); check("R6 clear ignored while high", v, 32'h20);
    irq_req[37] = 1'b0;
    step();
    rd(8'h14, v, va); check("R6 follows level low", v, 0);

    // R7: source 0 edge latch
    wr(8'h40, 32'hffff_ffff);
    irq_req[0] = 1'b1;
    step();
    rd(8'h10, v, va); check("R7 src0 latched", v, 32'h1);
    rd(8'h00, v, va); check("R2 src0 vector reads zero", v, 0);
    step();
    check("R5 irq from src0", 32'(irq), 1);
    wr(8'h10, 32'h0);
    rd(8'h10, v, va); check("R9 write zero keeps src0", v, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h10, v, va); check("R7 clear wins over held line", v, 0);
    step();
    rd(8'h10, v, va); check("R7 held line no re-latch", v, 0);
    irq_req[0] = 1'b0;
    step();
    irq_req[0] = 1'b1;
    step();
    rd(8'h10, v, va); check("R7 new edge latches", v, 32'h1);
    irq_req[0] = 1'b0;
    wr(8'h10, 32'hffff_ffff);
    rd(8'h10, v, va); check("R9 all-ones clears src0", v, 0);

    // R8: level mode for source 0
    wr(8'h0c, 32'h1);
    irq_req[0] = 1'b1;
    step();
    rd(8'h10, v, va); check("R8 level sets src0", v, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h10, v, va); check("R8 line beats clear", v, 32'h1);
    irq_req[0] = 1'b0;
    step();
    rd(8'h10, v, va); check("R8 latched after drop", v, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h10, v, va); check("R8 clear after drop", v, 0);

    // R10
    rd(8'h0c, v, va); check("R10 extctl readback", v, 32'h1);
    wr(8'h08, 32'hffff_ffff);
    rd(8'h08, v, va); check("R10 prot bit0 only", v, 32'h1);
    wr(8'h0c, 32'h0);
    rd(8'h0c, v, va); check("R10 extctl cleared", v, 0);

    // R11: alternate layout
    wr(8'h20, 32'ha5a5_0f0f);
    rd(8'h20, v, va);
    check("R11 alt enable at 0x20", va, 32'ha5a5_0f0f);
    check("R11 default 0x20 unmapped", v, 0);
    wr(8'h34, 32'h0000_1234);
    rd(8'h34, v, va); check("R11 alt mask at 0x34", va, 32'h0000_1234);
    rd(8'h40, v, va); check("R11 default enable at 0x40", v, 32'hffff_ffff);

    // R12: unmapped offsets
    wr(8'h04, 32'hffff_ffff);
    rd(8'h04, v, va); check("R12 unmapped write ignored", v, 0);
    rd(8'hfc, v, va); check("R12 unmapped read zero", v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule